// File: doc/BRIEF.md
# Sequential Restoring Square Root Unit

This block computes the square root of a normalized radicand in the range [1, 4), one root bit per clock. The radicand is a fixed-point value with two integer bits and `2*FRAC_W` fraction bits. The root comes out as `1.` followed by `FRAC_W` fraction bits. The unit also returns the exact final remainder.

A one-cycle start pulse captures the operand. The unit first assumes the integer root bit is 1, so its first partial remainder is z − 1. Each later cycle doubles the remainder and subtracts a trial term built from the partial root. The sign of the result picks the next root bit. In restoring mode, a negative trial is discarded and the doubled remainder is kept. In non-restoring mode, each digit is +1 or −1. When the final remainder is negative, the last step is undone.

After the last root bit, the unit takes one extra cycle to finish. It then raises `done_o` for exactly one cycle. The results stay on the outputs until the next operation completes.

Top module: `sqrt_seq_unit`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `root_o` and `rem_o` are all zero.
- R2: A `start_i` pulse seen while idle makes `busy_o` high on the following cycle.
- R3: `done_o` rises exactly `FRAC_W + 2` clock edges after the edge that samples the start pulse, and it stays high for one cycle only. The start edge counts as the first of these edges.
- R4: In restoring mode (`mode_nr_i` = 0), `root_o` equals floor(sqrt(Z)), where Z is the integer value of `z_i`. Bit `FRAC_W` of `root_o` is always 1. For Z = 7552 (118/64), the root is 86 (binary 1.010110).
- R5: `rem_o` equals Z − root_o², in units of 2^−2·FRAC_W. The remainder is never negative and never exceeds 2·root_o. For Z = 7552, the remainder is 156.
- R6: In non-restoring mode (`mode_nr_i` = 1), the final correction makes `root_o` and `rem_o` the same as in restoring mode for every radicand. For Z = 7552, the uncorrected root 87 becomes 86.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The timing and the result of the running operation do not change, and the new operand is not computed.
- R8: `root_o` and `rem_o` hold their values at every edge except the edge that raises `done_o`.
- R9: At the range ends, Z = 2^2·FRAC_W gives a root of 2^FRAC_W and a remainder of 0. Z = 2^(2·FRAC_W+2) − 1 gives a root of 2^(FRAC_W+1) − 1 and a remainder of Z − root².

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin; used only while idle |
| mode_nr_i | input | 1 | Digit mode sampled with start: 0 restoring, 1 non-restoring |
| z_i | input | 2*FRAC_W+2 | Radicand, 2 integer bits and 2*FRAC_W fraction bits, value in [1,4) |
| busy_o | output | 1 | High from the cycle after start until done is raised |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| root_o | output | FRAC_W+1 | Root as 1.f, FRAC_W fraction bits |
| rem_o | output | FRAC_W+2 | Final remainder, weight 2^-2*FRAC_W |

## Verification
The hardest case to reach from the ports is a non-restoring run that ends with a negative remainder. Only then does the final correction change the result. The bench drives 118/64, which is known to end this way, and sweeps a stride of radicands in both modes. It compares each pair of results against an integer square root computed in the bench. A second start pulse injected partway through a run checks that the captured operand and the completion timing are left untouched.

// File: rtl/sqrt_seq_pkg.sv
// Package: shared state encoding for the sequential square root unit.
package sqrt_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } sqrt_state_e;
endpackage

// File: rtl/sqrt_trial_step.sv
// sqrt_trial_step: combinational logic for one root-digit iteration.
// Doubles the partial remainder and forms the trial difference against
// 2*q +/- w, where w is the weight of the current digit. It then selects
// the next remainder and partial root.
// Assumes: s_i has 2*F fraction bits; q_i and wt_i have F fraction bits.
module sqrt_trial_step #(
    parameter int F  = 6,
    parameter int SW = 2*F + 5
) (
    input  logic [SW-1:0] s_i,
    input  logic [F:0]    q_i,
    input  logic [F:0]    wt_i,
    input  logic          nr_i,
    output logic [SW-1:0] s_o,
    output logic [F:0]    q_o
);
    localparam int PADW = SW - F - 1;

    logic [SW-1:0] q_ext, wt_ext, two_s, term_sub, term_add, trial;

    // Purpose: widen operands and build the two candidate correction terms.
    always_comb begin
        q_ext    = {{PADW{1'b0}}, q_i};
        wt_ext   = {{PADW{1'b0}}, wt_i};
        two_s    = s_i << 1;
        term_sub = ((q_ext << 1) + wt_ext) << F;
        term_add = ((q_ext << 1) - wt_ext) << F;
        trial    = two_s - term_sub;
    end

    // Purpose: pick the next remainder and root, by the digit rule of the mode.
    always_comb begin
        if (nr_i) begin
            if (!s_i[SW-1]) begin
                s_o = trial;
                q_o = q_i + wt_i;
            end else begin
                s_o = two_s + term_add;
                q_o = q_i - wt_i;
            end
        end else begin
            if (!trial[SW-1]) begin
                s_o = trial;
                q_o = q_i | wt_i;
            end else begin
                s_o = two_s;
                q_o = q_i;
            end
        end
    end
endmodule

// File: rtl/sqrt_finish.sv
// sqrt_finish: final correction and the result registers.
// In non-restoring mode, a negative last remainder is repaired: the root
// loses its last unit and 2q - 1 (scaled) is added back to the remainder.
// The registers load only when en_i is high.
// Assumes: s_i holds 2^F times the true remainder, with 2*F fraction bits.
module sqrt_finish #(
    parameter int F  = 6,
    parameter int SW = 2*F + 5,
    parameter int RW = F + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [SW-1:0] s_i,
    input  logic [F:0]    q_i,
    input  logic          nr_i,
    output logic [F:0]    root_o,
    output logic [RW-1:0] rem_o
);
    localparam int PADW = SW - F - 1;

    logic [SW-1:0] s_fix;
    logic [F:0]    q_fix;

    // Purpose: undo the last +1 digit when the non-restoring remainder is negative.
    always_comb begin
        if (nr_i && s_i[SW-1]) begin
            s_fix = s_i + ((({{PADW{1'b0}}, q_i} << 1) - 1'b1) << F);
            q_fix = q_i - 1'b1;
        end else begin
            s_fix = s_i;
            q_fix = q_i;
        end
    end

    // Purpose: capture the corrected root and remainder at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_o <= '0;
            rem_o  <= '0;
        end else if (en_i) begin
            root_o <= q_fix;
            rem_o  <= s_fix[F +: RW];
        end
    end

    // R5: the corrected remainder is non-negative and has no bits below 2^-2F.
    p_rem_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (s_fix[F-1:0] == '0) && (s_fix[SW-1:F+RW] == '0));

    // R4: every stored root has its integer bit set.
    p_root_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) |-> root_o[F]);
endmodule

// File: rtl/sqrt_seq_unit.sv
// sqrt_seq_unit: multicycle shift/subtract square root, one bit per clock.
// On start, it loads s = z - 1 and q = 1, then runs F iterations and one
// finish cycle, and pulses done. EN_NR = 0 removes the non-restoring mode.
// Assumes: z_i is normalized to [1,4); start_i is ignored while busy.
module sqrt_seq_unit #(
    parameter int FRAC_W = 6,
    parameter bit EN_NR  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  mode_nr_i,
    input  logic [2*FRAC_W+1:0]   z_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [FRAC_W:0]       root_o,
    output logic [FRAC_W+1:0]     rem_o
);
    import sqrt_seq_pkg::*;

    localparam int F  = FRAC_W;
    localparam int ZW = 2*F + 2;
    localparam int SW = 2*F + 5;
    localparam int RW = F + 2;
    localparam logic [SW-1:0] ONE_S  = {{(SW-1){1'b0}}, 1'b1} << (2*F);
    localparam logic [F:0]    ONE_Q  = {{F{1'b0}}, 1'b1} << F;
    localparam logic [F:0]    FIRST_W = {{F{1'b0}}, 1'b1} << (F-1);

    sqrt_state_e   st;
    logic [SW-1:0] s_r, s_nxt;
    logic [F:0]    q_r, q_nxt, wt_r;
    logic          nr_r, nr_in;

    // Purpose: choose whether the mode input exists in this build.
    generate
        if (EN_NR) begin : g_nr
            assign nr_in = mode_nr_i;
        end else begin : g_rest
            logic unused_mode;
            assign unused_mode = mode_nr_i;
            assign nr_in = 1'b0;
        end
    endgenerate

    sqrt_trial_step #(.F(F), .SW(SW)) u_step (
        .s_i (s_r),
        .q_i (q_r),
        .wt_i(wt_r),
        .nr_i(nr_r),
        .s_o (s_nxt),
        .q_o (q_nxt)
    );

    sqrt_finish #(.F(F), .SW(SW), .RW(RW)) u_fin (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (st == ST_FIX),
        .s_i   (s_r),
        .q_i   (q_r),
        .nr_i  (nr_r),
        .root_o(root_o),
        .rem_o (rem_o)
    );

    // Purpose: sequencing, operand capture and the per-bit iteration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            s_r    <= '0;
            q_r    <= '0;
            wt_r   <= '0;
            nr_r   <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                ST_IDLE: if (start_i) begin
                    s_r  <= {{(SW-ZW){1'b0}}, z_i} - ONE_S;
                    q_r  <= ONE_Q;
                    wt_r <= FIRST_W;
                    nr_r <= nr_in;
                    st   <= ST_RUN;
                end
                ST_RUN: begin
                    s_r  <= s_nxt;
                    q_r  <= q_nxt;
                    wt_r <= wt_r >> 1;
                    if (wt_r[0]) st <= ST_FIX;
                end
                ST_FIX: begin
                    done_o <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Purpose: the unit is busy whenever it is not idle.
    assign busy_o = (st != ST_IDLE);

    // R2: an accepted start makes the unit busy on the next cycle.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3: done is a single-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: a restoring-mode partial remainder is never negative.
    p_rest_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !nr_r) |-> !s_r[SW-1]);

    // R5: the final remainder never exceeds twice the root.
    p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({1'b0, rem_o} <= ({2'b00, root_o} << 1)));

    // R7: a start during a run does not change the captured mode.
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(nr_r));

    // R8: the results change only together with the done pulse.
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(root_o) && $stable(rem_o)));
endmodule

// File: tb/tb_sqrt_seq_unit.sv
// tb_sqrt_seq_unit: directed tests for the sequential square root unit.
module tb_sqrt_seq_unit;
    localparam int F  = 6;
    localparam int ZW = 2*F + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_nr_i = 1'b0;
    logic [ZW-1:0] z_i = '0;
    logic          busy_o, done_o;
    logic [F:0]    root_o;
    logic [F+1:0]  rem_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sqrt_seq_unit #(.FRAC_W(F), .EN_NR(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_nr_i(mode_nr_i),
        .z_i(z_i), .busy_o(busy_o), .done_o(done_o), .root_o(root_o), .rem_o(rem_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int isqrt(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    // One operation. Optionally injects a second start at cycle 3.
    // Checks latency, pulse width, output hold and the result.
    task automatic run_op(input int z, input bit nr, input bit inj, input int z2);
        int exp_q = isqrt(z);
        int exp_r = z - exp_q * exp_q;
        int old_q, old_r;
        int seen = 0;
        @(negedge clk);
        old_q = int'(root_o);
        old_r = int'(rem_o);
        start_i = 1'b1; z_i = ZW'(z); mode_nr_i = nr;
        for (int n = 1; n <= F + 6; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (inj && n == 3) begin
                start_i = 1'b1; z_i = ZW'(z2); mode_nr_i = ~nr;
            end
            if (n == 1) chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
            if (done_o === 1'b1) begin
                if (seen == 0) chk(n == F + 2, "R3 done latency", n, F + 2);
                else chk(1'b0, "R3 done width", n, F + 2);
                seen++;
                chk(int'(root_o) == exp_q, nr ? "R6 nr root" : "R4 root", int'(root_o), exp_q);
                chk(int'(rem_o) == exp_r, nr ? "R6 nr remainder" : "R5 remainder", int'(rem_o), exp_r);
                if (inj) chk(int'(root_o) == exp_q, "R7 injected start ignored", int'(root_o), exp_q);
            end else if (seen == 0) begin
                if (int'(root_o) != old_q || int'(rem_o) != old_r)
                    chk(1'b0, "R8 outputs held while busy", int'(root_o), old_q);
            end
            if (n == F + 3 && inj)
                chk(busy_o === 1'b0, "R7 no second run", int'(busy_o), 0);
        end
        start_i = 1'b0;
        if (seen == 0) chk(1'b0, "R3 done never seen", 0, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0, "R1 busy reset", int'(busy_o), 0);
        chk(done_o === 1'b0, "R1 done reset", int'(done_o), 0);
        chk(root_o === '0, "R1 root reset", int'(root_o), 0);
        chk(rem_o === '0, "R1 rem reset", int'(rem_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_example();
        run_op(7552, 1'b0, 1'b0, 0);
        chk(int'(root_o) == 86, "R4 example root 1.010110", int'(root_o), 86);
        chk(int'(rem_o) == 156, "R5 example remainder", int'(rem_o), 156);
        run_op(7552, 1'b1, 1'b0, 0);
        chk(int'(root_o) == 86, "R6 corrected 87 to 86", int'(root_o), 86);
    endtask

    task automatic t_bounds();
        run_op(4096, 1'b0, 1'b0, 0);
        chk(int'(root_o) == 64 && int'(rem_o) == 0, "R9 lower end", int'(root_o), 64);
        run_op(16383, 1'b1, 1'b0, 0);
        chk(int'(root_o) == 127 && int'(rem_o) == 254, "R9 upper end", int'(rem_o), 254);
    endtask

    task automatic t_busy_start();
        run_op(9000, 1'b0, 1'b1, 15000);
        run_op(5000, 1'b1, 1'b1, 4100);
    endtask

    task automatic t_sweep();
        for (int z = 4096; z < 16384; z += 37) begin
            run_op(z, 1'b0, 1'b0, 0);
            run_op(z, 1'b1, 1'b0, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_bounds();
        t_busy_start();
        t_sweep();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule